// File: doc/BRIEF.md
# Parallel-to-Serial Transmit Serializer

This block turns a parallel word of up to ten bits into a serial bit stream on a fast bit clock. The word is first captured into a holding (load) register on the core-clock edge. The core clock is synchronous to the bit clock divided by the serialization factor, and its edge is marked in the bit-clock domain by a one-cycle `core_tick` pulse. A periodic `load_en` strobe then moves the held word into a shift register, which sends it most significant bit first, one bit per bit-clock cycle.

The number of bits sent per word is programmable from 3 to 10. Only that many of the word's most significant bits are sent, and the strobe is expected once every that many cycles. A strobe that arrives while bits are still queued discards them and raises a one-cycle error flag. Two bypass modes skip serialization. Single-rate mode sends one bit per cycle. Double-rate mode sends two bits per cycle, and its two output slots stand for the two halves of the bit period.

Top module: `sertx_serializer`

## Requirements
- R1: While `rst_n` is low, and after its release until the first `load_en`, `tx_bits` is 0 in serial mode and `tx_err` is 0. The load and shift registers are cleared.
- R2: The load register takes `par_data` on a clock edge where `core_tick` is 1 and holds its value otherwise. A `load_en` on the same edge moves the previously held word.
- R3: On an edge where `load_en` is 1, the shift register takes the held word, and its bit W-1 appears on both `tx_bits` slots in the following cycle. Lower bits follow one per cycle, MSB first.
- R4: With effective factor J, only bits W-1 down to W-J of the held word are sent. After those J cycles, with no new strobe, the serial output is 0.
- R5: The effective factor is the `factor` value sampled at the strobe. A value below 3 is treated as 3, and a value above W (10) is treated as W.
- R6: Strobes spaced exactly J cycles apart give an unbroken stream with `tx_err` held at 0.
- R7: A strobe that arrives while more than the currently shown bit is still queued drops the rest. The new word starts at once, and `tx_err` is 1 for the single cycle after that edge.
- R8: `mode` = 2'b01 (single rate): both `tx_bits` slots equal bit W-1 of the load register.
- R9: `mode` = 2'b10 (double rate): `tx_bits[1]` (the first half-period slot) equals load-register bit W-1 and `tx_bits[0]` equals bit W-2.
- R10: `mode` = 2'b00 and 2'b11 both select full serialization, and both slots carry the same serial bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_tick | input | 1 | Core-clock edge marker; captures `par_data` |
| par_data | input | W (10) | Parallel word, MSB sent first |
| load_en | input | 1 | Strobe moving the held word into the shift register |
| factor | input | CW (4) | Requested bits per word (3..10, clamped) |
| mode | input | 2 | 00/11 serial, 01 single rate, 10 double rate |
| tx_bits | output | 2 | Output slots: [1] first half-period, [0] second |
| tx_err | output | 1 | One-cycle flag for a premature strobe |

## Verification
Every result passes through exactly one register, so each result appears in the cycle after the edge that causes it. A load strobe shows the new MSB one cycle later. A core tick changes the bypass outputs one cycle later. The error flag rises one cycle after the premature strobe. A change of `mode` alone acts within the same cycle. The bench drives inputs on the falling edge, steps its queue model on the rising edge, and compares both outputs 2 ns after every rising edge. This means each comparison already includes the one register stage and the current mode.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [1:0] {
    TXM_SERIAL  = 2'b00,
    TXM_SINGLE  = 2'b01,
    TXM_DOUBLE  = 2'b10,
    TXM_SERIAL2 = 2'b11
  } tx_mode_e;

  localparam int FACTOR_MIN = 3;

  // Effective bits per word for a requested factor and word width.
  function automatic int eff_factor(input int req, input int width);
    if (req < FACTOR_MIN) return FACTOR_MIN;
    if (req > width) return width;
    return req;
  endfunction

  // Nonzero when bit position pos lies among the top j of width bits.
  function automatic logic keep_bit(input int pos, input int j, input int width);
    return (pos >= width - j);
  endfunction

endpackage

// File: rtl/sertx_load_reg.sv
module sertx_load_reg #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  logic [W-1:0] din,
  output logic [W-1:0] word
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) word <= '0;
    else if (capture) word <= din;
  end
endmodule

// File: rtl/sertx_shift_eng.sv
module sertx_shift_eng
  import sertx_pkg::*;
#(
  parameter int W  = 10,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [W-1:0]  word,
  input  logic [CW-1:0] factor,
  output logic          ser_bit,
  output logic [CW-1:0] pending,
  output logic          drop_evt,
  output logic          err
);
  logic [W-1:0]  sh_q;
  logic [CW-1:0] pend_q;
  logic [W-1:0]  keep_mask;
  int            j_eff;

  always_comb begin
    j_eff = eff_factor(int'(factor), W);
    for (int i = 0; i < W; i++) keep_mask[i] = keep_bit(i, j_eff, W);
  end

  assign drop_evt = load_en && (pend_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      pend_q <= '0;
      err    <= 1'b0;
    end else if (load_en) begin
      sh_q   <= word & keep_mask;
      pend_q <= CW'(j_eff - 1);
      err    <= drop_evt;
    end else begin
      sh_q   <= {sh_q[W-2:0], 1'b0};
      if (pend_q != '0) pend_q <= pend_q - 1'b1;
      err    <= 1'b0;
    end
  end

  assign ser_bit = sh_q[W-1];
  assign pending = pend_q;
endmodule

// File: rtl/sertx_out_mux.sv
module sertx_out_mux
  import sertx_pkg::*;
#(
  parameter int W = 10
) (
  input  logic [1:0]   mode,
  input  logic         ser_bit,
  input  logic [W-1:0] word,
  output logic [1:0]   tx_bits
);
  always_comb begin
    case (tx_mode_e'(mode))
      TXM_SINGLE: tx_bits = {word[W-1], word[W-1]};
      TXM_DOUBLE: tx_bits = {word[W-1], word[W-2]};
      default:    tx_bits = {ser_bit, ser_bit};
    endcase
  end
endmodule

// File: rtl/sertx_serializer.sv
module sertx_serializer #(
  parameter int W  = 10,
  parameter int CW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          core_tick,
  input  logic [W-1:0]  par_data,
  input  logic          load_en,
  input  logic [CW-1:0] factor,
  input  logic [1:0]    mode,
  output logic [1:0]    tx_bits,
  output logic          tx_err
);
  logic [W-1:0]  held_word;
  logic          ser_bit;
  logic [CW-1:0] pend_w;
  logic          drop_evt;

  sertx_load_reg #(.W(W)) u_load (
    .clk(clk), .rst_n(rst_n), .capture(core_tick), .din(par_data), .word(held_word)
  );

  sertx_shift_eng #(.W(W), .CW(CW)) u_shift (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .word(held_word), .factor(factor),
    .ser_bit(ser_bit), .pending(pend_w), .drop_evt(drop_evt), .err(tx_err)
  );

  sertx_out_mux #(.W(W)) u_mux (
    .mode(mode), .ser_bit(ser_bit), .word(held_word), .tx_bits(tx_bits)
  );
endmodule

// File: rtl/sertx_serializer_chk.sv
module sertx_serializer_chk
  import sertx_pkg::*;
#(
  parameter int W  = 10,
  parameter int CW = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          load_en,
  input logic [CW-1:0] factor,
  input logic [1:0]    mode,
  input logic [1:0]    tx_bits,
  input logic          tx_err,
  input logic          ser_bit,
  input logic [CW-1:0] pend,
  input logic          drop_evt
);
  // R7: the error flag only follows a strobe that dropped bits
  a_r7_err_after_drop: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err |-> $past(load_en) && $past(drop_evt));

  // R4: queued count never exceeds the word width
  a_r4_pend_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pend <= CW'(W - 1));

  // R5: after a strobe the queue holds the clamped factor minus the shown bit
  a_r5_pend_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> pend == CW'(eff_factor(int'($past(factor)), W) - 1));

  // R4: an empty queue without a strobe leaves the serial bit at 0
  a_r4_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && pend == '0) |=> !ser_bit);

  // R8 / R10: single rate and serial modes drive both slots alike
  a_r8_single_slots: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b10) |-> tx_bits[1] == tx_bits[0]);

  // R1: first cycle after reset release shows a clear state
  a_r1_reset_clear: assert property (@(posedge clk)
    $rose(rst_n) |-> !tx_err && pend == '0);
endmodule

bind sertx_serializer sertx_serializer_chk #(.W(W), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .load_en(load_en), .factor(factor), .mode(mode),
  .tx_bits(tx_bits), .tx_err(tx_err), .ser_bit(ser_bit), .pend(pend_w),
  .drop_evt(drop_evt)
);

// File: tb/sertx_serializer_tb.sv
module sertx_serializer_tb;
  localparam int W  = 10;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_tick = 1'b0;
  logic          load_en = 1'b0;
  logic [W-1:0]  par = '0;
  logic [CW-1:0] factor = 4'd10;
  logic [1:0]    mode = 2'b00;
  wire  [1:0]    tx_bits;
  wire           tx_err;

  always #5 clk = ~clk;

  sertx_serializer #(.W(W), .CW(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .core_tick(core_tick), .par_data(par),
    .load_en(load_en), .factor(factor), .mode(mode), .tx_bits(tx_bits), .tx_err(tx_err)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  string tag = "R1";
  bit    done = 0;

  // Behavioural model: a queue of pending bits and a held word
  bit           q[$];
  logic [W-1:0] m_word = '0;
  bit           m_err = 0;

  always @(posedge clk) begin
    logic [1:0] exp_bits;
    int         nbits;
    bit         b;
    if (!rst_n) begin
      q.delete();
      m_word = '0;
      m_err = 0;
    end else begin
      if (load_en) begin
        m_err = (q.size() > 1);
        q.delete();
        nbits = int'(factor);
        if (nbits > W) nbits = W;
        if (nbits < 3) nbits = 3;
        for (int i = 0; i < nbits; i++) q.push_back(m_word[W-1-i]);
      end else begin
        m_err = 0;
        if (q.size() > 0) void'(q.pop_front());
      end
      if (core_tick) m_word = par;
    end
    #2;
    b = (q.size() > 0) ? q[0] : 1'b0;
    case (mode)
      2'b01:   exp_bits = {m_word[W-1], m_word[W-1]};
      2'b10:   exp_bits = {m_word[W-1], m_word[W-2]};
      default: exp_bits = {b, b};
    endcase
    n_cmp++;
    if (tx_bits !== exp_bits) begin
      n_bad++;
      $display("FAIL %s tx_bits got %b expected %b at %0t", tag, tx_bits, exp_bits, $time);
    end
    n_cmp++;
    if (tx_err !== m_err) begin
      n_bad++;
      $display("FAIL %s tx_err got %b expected %b at %0t", tag, tx_err, m_err, $time);
    end
  end

  logic [W-1:0] seed = 10'h2b5;

  function automatic logic [W-1:0] next_word(input logic [W-1:0] s);
    return W'((int'(s) * 37 + 113) % 1024);
  endfunction

  task automatic idle(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      load_en = 0;
      core_tick = 0;
    end
  endtask

  // Strobe every j cycles; a fresh word is captured one cycle after each strobe
  task automatic stream(input int words, input int j);
    for (int k = 0; k < words; k++) begin
      for (int c = 0; c < j; c++) begin
        @(negedge clk);
        load_en = (c == 0);
        core_tick = (c == 1);
        if (c == 1) begin
          seed = next_word(seed);
          par = seed;
        end
      end
    end
  endtask

  task automatic bypass_run(input int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      load_en = 0;
      core_tick = 1;
      seed = next_word(seed);
      par = seed;
    end
  endtask

  initial begin
    // R1: reset state and idle after release
    idle(4);
    @(negedge clk); rst_n = 1;
    idle(4);
    // prime the load register, then the first strobe (R3)
    @(negedge clk); core_tick = 1; par = 10'b1011001110;
    tag = "R3"; stream(1, 10);
    tag = "R6"; factor = 4'd10; stream(6, 10);
    tag = "R4"; factor = 4'd7; stream(5, 7);
    idle(12);
    tag = "R5"; factor = 4'd0; stream(5, 3);
    factor = 4'd15; stream(3, 10);
    idle(3);
    // R7: premature strobes at several depths
    tag = "R7"; factor = 4'd8;
    stream(1, 3);
    stream(1, 1);
    stream(1, 5);
    stream(2, 8);
    idle(10);
    tag = "R8"; mode = 2'b01; bypass_run(10);
    tag = "R2";
    for (int c = 0; c < 6; c++) begin
      @(negedge clk); core_tick = 0; par = ~par;
    end
    tag = "R9"; mode = 2'b10; bypass_run(10);
    tag = "R10"; mode = 2'b11; factor = 4'd5; stream(6, 5);
    mode = 2'b00; stream(3, 5);
    idle(8);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired in %s", tag);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule